// File: doc/BRIEF.md
# USB Host Interrupt Status Unit

This unit holds the pending-interrupt byte of a USB host port. It catches one-cycle event pulses from two packet engines and from the 1 ms frame timer. It also watches the decoded bus line state for cable attach and detach. Software reads the byte and clears pending bits by writing ones. A single request line combines the pending bits through an enable byte.

Attach and detach are found from the line-state flags. Both flags are registered. A new state counts only after it has been seen on enough consecutive samples, so a short glitch has no effect. Bit 6 has two uses, picked by a mode input: a latched resume interrupt, or a live "no device" indicator taken from the filtered line state. Bit 7 always shows the raw D+ level, so software can tell full speed from low speed after an attach.

Top module: `usbh_irq_status`

## Requirements
- R1: A write with `wr_en` high clears every latched bit whose `wr_data` bit is 1. Bits written with 0 keep their value.
- R2: A `done_a` pulse sets bit 0 and a `done_b` pulse sets bit 1. Each bit becomes readable one clock after the pulse.
- R3: A `sof_tick` pulse sets bit 4 one clock later.
- R4: The filtered line state starts as SE0 after reset. Bit 5 is set whenever that state changes from SE0 to IDLE or from IDLE to SE0. With STABLE_N = 2, a change applied before clock edge 1 updates the filtered state at edge 3 and sets bit 5 at edge 4.
- R5: A new line state held for fewer than STABLE_N consecutive samples changes nothing. A state that is neither SE0 (`line_se0`=1, `line_idle`=0) nor IDLE (`line_se0`=0, `line_idle`=1) is never taken as the filtered state.
- R6: When `resume_mode` is 1, bit 6 reads the latched resume interrupt. That interrupt is set by a `resume_evt` pulse and cleared by writing 1 to bit 6. Resume pulses that arrive while `resume_mode` is 0 are not latched.
- R7: When `resume_mode` is 0, bit 6 reads 1 while the filtered line state is SE0 (no device) and 0 otherwise.
- R8: Bit 7 of `stat_rd` always equals the current `dplus` input, with no register in the path.
- R9: Bits 2 and 3 of `stat_rd` always read 0. Writing ones to them has no effect.
- R10: If a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R11: `irq` is the OR of the pending bits ANDed with `irq_en`. The pending bits are bits 0, 1, 4 and 5, plus bit 6 only in resume mode. Bit 7 and the reserved bits never raise `irq`.
- R12: After reset all latched bits are 0, so `stat_rd` reads `{dplus, ~resume_mode, 6'b0}` and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_a | input | 1 | Transfer-done pulse, packet engine A |
| done_b | input | 1 | Transfer-done pulse, packet engine B |
| sof_tick | input | 1 | 1 ms frame timer pulse |
| resume_evt | input | 1 | Resume-detected pulse |
| resume_mode | input | 1 | 1: bit 6 is resume interrupt; 0: bit 6 is no-device flag |
| line_se0 | input | 1 | Decoded bus SE0 flag |
| line_idle | input | 1 | Decoded bus IDLE flag |
| dplus | input | 1 | Raw D+ level |
| wr_en | input | 1 | Write strobe for clearing |
| wr_data | input | 8 | Clear mask; 1 clears the bit |
| irq_en | input | 8 | Per-bit enable for `irq` |
| stat_rd | output | 8 | Status byte read value |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong bit in the sticky bank shows on `stat_rd` and `irq` one clock after the event or write that caused it. The bench sweeps all 256 clear masks with every event bit set, so a missing or misrouted clear is visible right away. A fault in the line filter shows as bit 5 or bit 6 changing at the wrong edge. For that reason the attach and detach sequences are checked at edges 2, 3 and 4 after the line change. Glitches and non-SE0/IDLE states are checked for the absence of any change across several cycles.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

   localparam int STAT_W = 8;
   localparam int BIT_DONE_A = 0;
   localparam int BIT_DONE_B = 1;
   localparam int BIT_SOF    = 4;
   localparam int BIT_LINK   = 5;
   localparam int BIT_SHARED = 6;
   localparam int BIT_DPLUS  = 7;
   localparam logic [STAT_W-1:0] LATCH_MASK = 8'b0111_0011;

   typedef enum logic [1:0] {
      LS_OTHER = 2'd0,
      LS_SE0   = 2'd1,
      LS_IDLE  = 2'd2
   } line_cls_t;

   function automatic line_cls_t classify(input logic se0, input logic idle);
      if (se0 && !idle)
         return LS_SE0;
      else if (idle && !se0)
         return LS_IDLE;
      else
         return LS_OTHER;
   endfunction

endpackage

// File: rtl/usbh_line_filter.sv
module usbh_line_filter
   import usbh_irq_pkg::*;
#(
   parameter int STABLE_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic se0_i,
   input  logic idle_i,
   output logic evt_o,
   output logic absent_o
);

   localparam int CW = $clog2(STABLE_N + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(STABLE_N);

   initial begin
      if (STABLE_N < 2)
         $error("usbh_line_filter: STABLE_N must be at least 2");
   end

   line_cls_t cls_q, cand_q, stable_q;
   logic [CW-1:0] cnt_q, cnt_nx;
   logic evt_q;

   always_comb begin
      if (cls_q != cand_q)
         cnt_nx = CW'(1);
      else if (cnt_q < CNT_TOP)
         cnt_nx = cnt_q + CW'(1);
      else
         cnt_nx = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q    <= LS_SE0;
         cand_q   <= LS_SE0;
         stable_q <= LS_SE0;
         cnt_q    <= CNT_TOP;
         evt_q    <= 1'b0;
      end else begin
         cls_q  <= classify(se0_i, idle_i);
         cand_q <= cls_q;
         cnt_q  <= cnt_nx;
         evt_q  <= 1'b0;
         if (cnt_nx == CNT_TOP && cls_q != LS_OTHER && cls_q != stable_q) begin
            stable_q <= cls_q;
            evt_q    <= 1'b1;
         end
      end
   end

   assign evt_o    = evt_q;
   assign absent_o = (stable_q == LS_SE0);

   // R4
   stable_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stable_q != $past(stable_q)) |-> evt_q);

   // R4
   evt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> (stable_q != $past(stable_q)));

   // R5
   glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> ($past(cls_q) == $past(cls_q, 2)));

endmodule

// File: rtl/usbh_sticky_bank.sv
module usbh_sticky_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_en_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   initial begin
      if (W < 1)
         $error("usbh_sticky_bank: W must be positive");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 1'b0;
         else if (set_i[i])
            q <= 1'b1;
         else if (clr_en_i && clr_i[i])
            q <= 1'b0;
      end
      assign q_o[i] = q;

      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_o[i]);

      // R1
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en_i && clr_i[i] && !set_i[i]) |=> !q_o[i]);

      // R1
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[i] && !(clr_en_i && clr_i[i])) |=> $stable(q_o[i]));
   end

endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status
   import usbh_irq_pkg::*;
#(
   parameter int STABLE_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_a,
   input  logic              done_b,
   input  logic              sof_tick,
   input  logic              resume_evt,
   input  logic              resume_mode,
   input  logic              line_se0,
   input  logic              line_idle,
   input  logic              dplus,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   input  logic [STAT_W-1:0] irq_en,
   output logic [STAT_W-1:0] stat_rd,
   output logic              irq
);

   initial begin
      if (STAT_W != 8)
         $error("usbh_irq_status: status byte must be 8 bits");
   end

   logic              link_evt;
   logic              absent;
   logic [STAT_W-1:0] set_v;
   logic [STAT_W-1:0] q_v;
   logic [STAT_W-1:0] pending;

   usbh_line_filter #(.STABLE_N(STABLE_N)) i_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .se0_i    (line_se0),
      .idle_i   (line_idle),
      .evt_o    (link_evt),
      .absent_o (absent)
   );

   always_comb begin
      set_v             = '0;
      set_v[BIT_DONE_A] = done_a;
      set_v[BIT_DONE_B] = done_b;
      set_v[BIT_SOF]    = sof_tick;
      set_v[BIT_LINK]   = link_evt;
      set_v[BIT_SHARED] = resume_evt & resume_mode;
   end

   usbh_sticky_bank #(.W(STAT_W)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_v),
      .clr_en_i (wr_en),
      .clr_i    (wr_data),
      .q_o      (q_v)
   );

   always_comb begin
      pending             = q_v & LATCH_MASK;
      pending[BIT_SHARED] = pending[BIT_SHARED] & resume_mode;
   end

   always_comb begin
      stat_rd             = pending;
      stat_rd[BIT_SHARED] = resume_mode ? q_v[BIT_SHARED] : absent;
      stat_rd[BIT_DPLUS]  = dplus;
   end

   assign irq = |(pending & irq_en);

   // R9
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd[3:2] == 2'b00) && !(pending[7]));

   // R6
   resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_evt && !resume_mode && !q_v[BIT_SHARED]) |=> !q_v[BIT_SHARED]);

endmodule

// File: tb/test_usbh_irq_status.sv
module test_usbh_irq_status;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       done_a = 1'b0, done_b = 1'b0, sof_tick = 1'b0, resume_evt = 1'b0;
   logic       resume_mode = 1'b0;
   logic       line_se0 = 1'b1, line_idle = 1'b0;
   logic       dplus = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] irq_en = 8'h00;
   logic [7:0] stat_rd;
   logic       irq;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   usbh_irq_status i_usbh_irq_status (
      .clk(clk), .rst_n(rst_n), .done_a(done_a), .done_b(done_b),
      .sof_tick(sof_tick), .resume_evt(resume_evt), .resume_mode(resume_mode),
      .line_se0(line_se0), .line_idle(line_idle), .dplus(dplus),
      .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
      .stat_rd(stat_rd), .irq(irq)
   );

   task automatic step(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      wr_en = 1'b1; wr_data = 8'hFF;
      step();
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] s;
      logic       s5;
      logic [7:0] p;
      step(3);
      rst_n = 1'b1;
      step();
      // R12 reset state, no device, presence mode
      chk("R12 reset stat", stat_rd, 8'h40);
      chk("R12 reset irq", {7'b0, irq}, 8'h00);

      // R8 live D+
      dplus = 1'b1; #1;
      chk("R8 dplus high", stat_rd, 8'hC0);
      dplus = 1'b0; #1;
      chk("R8 dplus low", stat_rd, 8'h40);

      // R4 / R7 attach: SE0 -> IDLE
      line_se0 = 1'b0; line_idle = 1'b1;
      step(2);
      chk("R4 attach edge2", stat_rd, 8'h40);
      step();
      chk("R7 attach edge3 present", stat_rd, 8'h00);
      step();
      chk("R4 attach edge4 bit5", stat_rd, 8'h20);

      // R1 write zero keeps, write one clears
      wr_en = 1'b1; wr_data = 8'h00; step(); wr_en = 1'b0;
      chk("R1 write zero keeps", stat_rd, 8'h20);
      wr_en = 1'b1; wr_data = 8'h20; step(); wr_en = 1'b0; wr_data = 8'h00;
      chk("R1 write one clears", stat_rd, 8'h00);

      // R5 single-sample glitch ignored
      line_se0 = 1'b1; line_idle = 1'b0;
      step();
      line_se0 = 1'b0; line_idle = 1'b1;
      step(5);
      chk("R5 glitch ignored", stat_rd, 8'h00);

      // R5 non SE0/IDLE state never taken
      line_se0 = 1'b1; line_idle = 1'b1;
      step(6);
      chk("R5 other state ignored", stat_rd, 8'h00);

      // R4 detach from IDLE through other state to SE0
      line_se0 = 1'b1; line_idle = 1'b0;
      step(3);
      chk("R4 detach edge3 absent", stat_rd, 8'h40);
      step();
      chk("R4 detach edge4 bit5", stat_rd, 8'h60);
      clear_all();

      // R2 / R3 single events
      done_a = 1'b1; step(); done_a = 1'b0;
      chk("R2 done_a bit0", stat_rd, 8'h41);
      done_b = 1'b1; step(); done_b = 1'b0;
      chk("R2 done_b bit1", stat_rd, 8'h43);
      sof_tick = 1'b1; step(); sof_tick = 1'b0;
      chk("R3 sof bit4", stat_rd, 8'h53);

      // R11 irq in presence mode: bit6 never contributes
      irq_en = 8'h40; #1;
      chk("R11 presence bit6 no irq", {7'b0, irq}, 8'h00);
      irq_en = 8'h10; #1;
      chk("R11 sof enabled irq", {7'b0, irq}, 8'h01);
      irq_en = 8'h8C; dplus = 1'b1; #1;
      chk("R11 bit7 reserved no irq", {7'b0, irq}, 8'h00);
      dplus = 1'b0; irq_en = 8'h00;

      // R10 set wins over clear
      wr_en = 1'b1; wr_data = 8'h01; done_a = 1'b1;
      step();
      wr_en = 1'b0; wr_data = 8'h00; done_a = 1'b0;
      chk("R10 set wins", stat_rd, 8'h53);

      // R9 reserved writes ignored
      wr_en = 1'b1; wr_data = 8'h0C; step(); wr_en = 1'b0; wr_data = 8'h00;
      chk("R9 reserved write", stat_rd, 8'h53);
      clear_all();

      // R6 resume ignored in presence mode, latched in resume mode
      resume_evt = 1'b1; step(); resume_evt = 1'b0;
      resume_mode = 1'b1; #1;
      chk("R6 resume gated in presence mode", stat_rd, 8'h00);
      resume_evt = 1'b1; step(); resume_evt = 1'b0;
      chk("R6 resume latched", stat_rd, 8'h40);
      irq_en = 8'h40; #1;
      chk("R11 resume irq", {7'b0, irq}, 8'h01);
      irq_en = 8'h00;
      wr_en = 1'b1; wr_data = 8'h40; step(); wr_en = 1'b0; wr_data = 8'h00;
      chk("R6 resume cleared", stat_rd, 8'h00);

      // Reattach to leave bit5 pending for the sweep (R4)
      line_se0 = 1'b0; line_idle = 1'b1;
      step(4);
      chk("R4 reattach bit5", stat_rd, 8'h20);

      // Exhaustive sweep of clear masks, resume mode (R1, R9, R11)
      s5 = 1'b1;
      for (int v = 0; v < 256; v++) begin
         done_a = 1'b1; done_b = 1'b1; sof_tick = 1'b1; resume_evt = 1'b1;
         step();
         done_a = 1'b0; done_b = 1'b0; sof_tick = 1'b0; resume_evt = 1'b0;
         wr_en = 1'b1; wr_data = 8'(v);
         irq_en = 8'(v) ^ 8'hA5;
         step();
         wr_en = 1'b0;
         s = (8'h53 | {2'b00, s5, 5'b0}) & ~8'(v);
         s5 = s[5];
         p = s & 8'h73;
         chk("R1 sweep stat", stat_rd, p);
         chk("R11 sweep irq", {7'b0, irq}, {7'b0, |(p & (8'(v) ^ 8'hA5))});
      end
      wr_data = 8'h00; irq_en = 8'h00;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule